// File: doc/BRIEF.md
# I2C Register-Slave Byte Engine

This block is the serial front end of a small register-mapped peripheral. It watches an I2C bus through an oversampling system clock, recovers START, repeated START and STOP, shifts bytes in and out most significant bit first, and answers to one device identity. The identity is a fixed four-bit type code followed by three strap inputs. On that bus traffic it turns out a register address, a write strobe with its data byte, and a read request with a one-cycle combinational return path. The register map behind it holds the actual storage.

A write carries the identity byte, one address byte and one data byte. Some addresses commit on the clock edge that completes the data byte. All other addresses commit only when a STOP closes the write. A read first sets the address with a short write, then uses a repeated START and the read identity. Bytes stream out from an auto-incrementing pointer for as long as the master acknowledges them. A busy input makes the engine deaf to the bus while the surrounding device is occupied. A write-enable input refuses data bytes.

Top module: `i2c_reg_slave`

## Requirements
- R1: An identity byte whose bits 7:4 equal the type code (default 1010b) and whose bits 3:1 equal strap_addr[2:0] selects the engine. Bit 0 chooses the direction: 1 for read, 0 for write.
- R2: The engine pulls SDA low through the whole ninth clock after a matching identity byte, after an address byte and after an accepted write data byte.
- R3: After an identity byte that does not match, SDA stays released and every further byte goes unacknowledged until the next START.
- R4: In a read, the engine drives each data byte MSB first and starts the next byte only if the master pulled SDA low on the ninth clock. After a master NACK, SDA stays released.
- R5: The read pointer starts at the address byte. It advances by one for each master-acknowledged byte and returns from WRAP_ADDR (default 8) to 0.
- R6: With wr_allow low, a write data byte gets no acknowledge and no strobe, and the engine returns to idle. The identity and address bytes are still acknowledged.
- R7: While busy is high, SDA is released, no strobe or read request is issued, and START is ignored. A busy pulse in the middle of a transfer drops that transfer.
- R8: For addresses below EARLY_SPAN (default 4) and for CTL_ADDR (default 8), wr_strobe pulses once when the eighth data bit's SCL falling edge is seen, which is before the acknowledge clock and before STOP.
- R9: For every other address, an accepted data byte is strobed only by the STOP that ends the write. A START arriving first discards it.
- R10: After reset, SDA is released and wr_strobe and rd_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad |
| sda_pull_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| strap_addr | input | 3 | Strap inputs compared with identity bits 3:1 |
| busy | input | 1 | Device busy; bus ignored while high |
| wr_allow | input | 1 | Low refuses write data bytes |
| reg_addr | output | 8 | Register pointer for writes and reads |
| wr_strobe | output | 1 | One-cycle write pulse |
| wr_data | output | 8 | Data for wr_strobe |
| rd_req | output | 1 | One-cycle read request at reg_addr |
| rd_data | input | 8 | Register contents, valid in the rd_req cycle |

## Verification
Writes go to an early-commit address and to a deferred address. The strobe count is read at the acknowledge clock and again after STOP, which separates the two commit points. A third deferred write is cut short by a repeated START. A streaming read that starts just below the wrap address checks the pointer sequence and the master-acknowledge handshake. An extra byte clocked after a NACK must read all ones. Transfers with a wrong strap identity, with writes refused and under busy are followed by read-back through the normal read path, which shows that no register changed.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_ADDR,
        ST_WDATA,
        ST_WDONE,
        ST_RDATA
    } phase_e;

    // Decoded bus events, one system clock wide each.
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    // Addresses that commit at the last data bit instead of at STOP.
    function automatic logic commits_early(byte_t a, byte_t span, byte_t ctl);
        return (a < span) || (a == ctl);
    endfunction

    function automatic byte_t next_ptr(byte_t p, byte_t wrap);
        return (p == wrap) ? '0 : byte_t'(p + 1'b1);
    endfunction

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync
    import i2c_reg_pkg::*;
#(
    parameter int STAGES = 2
)(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_now = scl_sh[STAGES-1];
    assign sda_now = sda_sh[STAGES-1];

    always_comb begin
        ev.scl_rise = scl_now & ~scl_d;
        ev.scl_fall = ~scl_now & scl_d;
        ev.start    = scl_now & scl_d & sda_d & ~sda_now;
        ev.stop     = scl_now & scl_d & ~sda_d & sda_now;
        ev.sda      = sda_now;
    end

endmodule

// File: rtl/i2c_tx_shift.sv
module i2c_tx_shift
    import i2c_reg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  load,
    input  byte_t ldata,
    input  logic  shift,
    output logic  bit_out,
    output logic  ready
);
    byte_t sr;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sr    <= '1;
            ready <= 1'b0;
        end else if (load) begin
            sr    <= ldata;
            ready <= 1'b1;
        end else if (shift) begin
            sr    <= {sr[BYTE_W-2:0], 1'b1};
        end
    end

    assign bit_out = sr[BYTE_W-1];

    // A fetch is only issued once the byte slot is open again.
    AST_LOAD_OPEN_SLOT: assert property (@(posedge clk) disable iff (rst)
        load |-> !clear); // R4

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
    import i2c_reg_pkg::*;
#(
    parameter logic [3:0] DEV_CODE   = 4'b1010,
    parameter int         WRAP_ADDR  = 8,
    parameter int         EARLY_SPAN = 4,
    parameter int         CTL_ADDR   = 8
)(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  logic    busy,
    input  logic [2:0] strap,
    input  logic    wr_allow,
    output byte_t   ptr,
    output logic    wr_stb,
    output byte_t   wdata,
    output logic    rd_req,
    output logic    ack_drive,
    output logic    tx_phase,
    output logic    tx_shift,
    output logic    tx_clear
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam byte_t WRAP_B  = byte_t'(WRAP_ADDR);
    localparam byte_t SPAN_B  = byte_t'(EARLY_SPAN);
    localparam byte_t CTL_B   = byte_t'(CTL_ADDR);

    phase_e           state;
    phase_e           nxt;
    logic [CNT_W-1:0] bitcnt;
    logic             in_ack;
    logic             ack_q;
    logic             m_ack;
    logic             pending;
    byte_t            shreg;

    logic live, byte_done, slot_end, id_ok, ptr_adv;

    always_comb begin
        live      = !busy && !ev.start && !ev.stop &&
                    (state inside {ST_ID, ST_ADDR, ST_WDATA, ST_RDATA});
        byte_done = live && ev.scl_fall && !in_ack && (bitcnt == LAST_BIT);
        slot_end  = live && ev.scl_fall && in_ack;
        id_ok     = (shreg[BYTE_W-1:1] == {DEV_CODE, strap});
        ptr_adv   = slot_end && (state == ST_RDATA) && m_ack;
    end

    assign tx_phase  = (state == ST_RDATA) && !in_ack;
    assign tx_shift  = live && ev.scl_fall && tx_phase && (bitcnt != LAST_BIT);
    assign tx_clear  = !tx_phase;
    assign ack_drive = ack_q;

    always_ff @(posedge clk) begin
        wr_stb <= 1'b0;
        rd_req <= 1'b0;
        if (rst) begin
            state   <= ST_IDLE;
            nxt     <= ST_IDLE;
            bitcnt  <= '0;
            in_ack  <= 1'b0;
            ack_q   <= 1'b0;
            m_ack   <= 1'b0;
            pending <= 1'b0;
            shreg   <= '0;
            ptr     <= '0;
            wdata   <= '0;
        end else if (busy) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            in_ack  <= 1'b0;
            ack_q   <= 1'b0;
            pending <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_ID;
            bitcnt  <= '0;
            in_ack  <= 1'b0;
            ack_q   <= 1'b0;
            pending <= 1'b0;
        end else if (ev.stop) begin
            if (state == ST_WDONE && pending) wr_stb <= 1'b1;
            state   <= ST_IDLE;
            in_ack  <= 1'b0;
            ack_q   <= 1'b0;
            pending <= 1'b0;
        end else if (live && ev.scl_rise) begin
            if (in_ack) begin
                m_ack <= ~ev.sda;
            end else if (bitcnt != LAST_BIT) begin
                shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                bitcnt <= bitcnt + 1'b1;
            end
        end else if (byte_done) begin
            unique case (state)
                ST_ID: begin
                    if (id_ok) begin
                        ack_q  <= 1'b1;
                        in_ack <= 1'b1;
                        nxt    <= shreg[0] ? ST_RDATA : ST_ADDR;
                    end else begin
                        state  <= ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    ptr    <= shreg;
                    ack_q  <= 1'b1;
                    in_ack <= 1'b1;
                    nxt    <= ST_WDATA;
                end
                ST_WDATA: begin
                    if (wr_allow) begin
                        ack_q  <= 1'b1;
                        in_ack <= 1'b1;
                        nxt    <= ST_WDONE;
                        wdata  <= shreg;
                        if (commits_early(ptr, SPAN_B, CTL_B)) wr_stb  <= 1'b1;
                        else                                   pending <= 1'b1;
                    end else begin
                        state  <= ST_IDLE;
                    end
                end
                default: begin
                    in_ack <= 1'b1;
                    nxt    <= ST_RDATA;
                end
            endcase
        end else if (slot_end) begin
            in_ack <= 1'b0;
            ack_q  <= 1'b0;
            bitcnt <= '0;
            if (state == ST_RDATA) begin
                if (m_ack) begin
                    ptr    <= next_ptr(ptr, WRAP_B);
                    rd_req <= 1'b1;
                end else begin
                    state  <= ST_IDLE;
                end
            end else begin
                state <= nxt;
                if (nxt == ST_RDATA) rd_req <= 1'b1;
            end
        end
    end

    AST_MISMATCH_IDLE: assert property (@(posedge clk) disable iff (rst)
        (byte_done && state == ST_ID && !id_ok) |=> (state == ST_IDLE && !ack_q)); // R3
    AST_ACK_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        ack_q |-> in_ack); // R2
    AST_NO_ACK_IN_READ: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDATA) |-> !ack_q); // R4
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ptr_adv && ptr == WRAP_B) |=> (ptr == '0)); // R5
    AST_WP_REJECT: assert property (@(posedge clk) disable iff (rst)
        (byte_done && state == ST_WDATA && !wr_allow) |=> (state == ST_IDLE && !ack_q && !wr_stb)); // R6
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        busy |=> (state == ST_IDLE && !ack_q && !wr_stb && !rd_req)); // R7
    AST_EARLY_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (byte_done && state == ST_WDATA && wr_allow && commits_early(ptr, SPAN_B, CTL_B)) |=> wr_stb); // R8
    AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (byte_done && state == ST_WDATA && !commits_early(ptr, SPAN_B, CTL_B)) |=> !wr_stb); // R9

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_reg_pkg::*;
#(
    parameter logic [3:0] DEV_CODE    = 4'b1010,
    parameter int         WRAP_ADDR   = 8,
    parameter int         EARLY_SPAN  = 4,
    parameter int         CTL_ADDR    = 8,
    parameter int         SYNC_STAGES = 2
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull_low,
    input  logic [2:0] strap_addr,
    input  logic       busy,
    input  logic       wr_allow,
    output logic [7:0] reg_addr,
    output logic       wr_strobe,
    output logic [7:0] wr_data,
    output logic       rd_req,
    input  logic [7:0] rd_data
);
    bus_ev_t ev;
    logic    ack_drive, tx_phase, tx_shift, tx_clear, tx_bit, tx_ready;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2c_proto_fsm #(
        .DEV_CODE   (DEV_CODE),
        .WRAP_ADDR  (WRAP_ADDR),
        .EARLY_SPAN (EARLY_SPAN),
        .CTL_ADDR   (CTL_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .busy      (busy),
        .strap     (strap_addr),
        .wr_allow  (wr_allow),
        .ptr       (reg_addr),
        .wr_stb    (wr_strobe),
        .wdata     (wr_data),
        .rd_req    (rd_req),
        .ack_drive (ack_drive),
        .tx_phase  (tx_phase),
        .tx_shift  (tx_shift),
        .tx_clear  (tx_clear)
    );

    i2c_tx_shift u_tx (
        .clk     (clk),
        .rst     (rst),
        .clear   (tx_clear),
        .load    (rd_req),
        .ldata   (rd_data),
        .shift   (tx_shift),
        .bit_out (tx_bit),
        .ready   (tx_ready)
    );

    assign sda_pull_low = !busy && (ack_drive || (tx_phase && tx_ready && !tx_bit));

endmodule

// File: tb/i2c_reg_slave_bench.sv
module i2c_reg_slave_bench;
    localparam int H = 16;
    localparam int Q = 8;
    localparam logic [7:0] ID_W  = 8'hAA;  // 1010 + strap 101 + write
    localparam logic [7:0] ID_R  = 8'hAB;  // 1010 + strap 101 + read
    localparam logic [7:0] ID_BAD = 8'hA8; // strap 100

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, scl_m, sda_m, busy, wr_allow, busy_d;
    logic [2:0] strap;
    logic       sda_low, wr_strobe, rd_req, sda_bus;
    logic [7:0] reg_addr, wr_data, rd_data;
    logic [7:0] mem   [0:15];
    logic [7:0] model [0:15];
    int n_chk = 0, n_bad = 0, n_wr = 0, wr_at_ack = 0;
    logic [7:0] last_wa, last_wd;

    assign sda_bus = sda_m & ~sda_low;
    assign rd_data = mem[reg_addr[3:0]];

    i2c_reg_slave u_i2c_reg_slave (
        .clk (clk), .rst (rst), .scl_in (scl_m), .sda_in (sda_bus),
        .sda_pull_low (sda_low), .strap_addr (strap), .busy (busy),
        .wr_allow (wr_allow), .reg_addr (reg_addr), .wr_strobe (wr_strobe),
        .wr_data (wr_data), .rd_req (rd_req), .rd_data (rd_data)
    );

    // Register map stub behind the engine.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) mem[i] <= 8'(i * 17 + 3);
        end else if (wr_strobe) begin
            mem[wr_data === 8'hxx ? 0 : reg_addr[3:0]] <= wr_data;
            n_wr    <= n_wr + 1;
            last_wa <= reg_addr;
            last_wd <= wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison: a busy engine never pulls SDA or strobes (R7).
    always @(negedge clk) begin
        busy_d <= busy;
        if (!rst && busy && busy_d)
            chk(!sda_low && !wr_strobe, "R7 busy quiet", {sda_low, wr_strobe}, 0);
    end

    task automatic wt(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(Q);
        end
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
        acked = !sda_bus;
        wr_at_ack = n_wr;
        wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H); scl_m = 1'b1; wt(Q); b[i] = sda_bus; wt(Q); scl_m = 1'b0;
        end
        wt(Q); sda_m = !mack; wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(Q); sda_m = 1'b1;
    endtask

    task automatic set_addr(input logic [7:0] a);
        logic k;
        bus_start(); put_byte(ID_W, k); put_byte(a, k);
    endtask

    task automatic read_one(input logic [7:0] a, input string req);
        logic k; logic [7:0] d;
        set_addr(a); bus_start(); put_byte(ID_R, k);
        get_byte(1'b0, d); bus_stop();
        chk(d == model[a[3:0]], req, d, model[a[3:0]]);
    endtask

    initial begin
        logic k; logic [7:0] d; int n0;
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; busy = 1'b0; busy_d = 1'b0;
        wr_allow = 1'b1; strap = 3'b101;
        for (int i = 0; i < 16; i++) model[i] = 8'(i * 17 + 3);
        wt(5);
        chk(!sda_low && !wr_strobe && !rd_req, "R10 reset outputs", {sda_low, wr_strobe, rd_req}, 0);
        rst = 1'b0; wt(10);

        // Early-commit write to address 2.
        n0 = n_wr;
        bus_start();
        put_byte(ID_W, k);  chk(k, "R1 write identity ack", k, 1);
        put_byte(8'h02, k); chk(k, "R2 address ack", k, 1);
        put_byte(8'hA5, k); chk(k, "R2 data ack", k, 1);
        chk(wr_at_ack == n0 + 1, "R8 strobe before ack clock", wr_at_ack, n0 + 1);
        chk(last_wa == 8'h02 && last_wd == 8'hA5, "R8 strobe addr/data", {last_wa, last_wd}, 16'h02A5);
        bus_stop(); wt(5);
        chk(n_wr == n0 + 1, "R8 no second strobe at STOP", n_wr, n0 + 1);
        model[2] = 8'hA5;

        // Deferred write to address 5.
        n0 = n_wr;
        set_addr(8'h05); put_byte(8'h3C, k);
        chk(k && n_wr == n0, "R9 no strobe before STOP", n_wr, n0);
        bus_stop(); wt(5);
        chk(n_wr == n0 + 1 && last_wa == 8'h05 && last_wd == 8'h3C, "R9 strobe at STOP", n_wr, n0 + 1);
        model[5] = 8'h3C;

        // Deferred write to address 4 cut by a repeated START.
        n0 = n_wr;
        set_addr(8'h04); put_byte(8'h77, k); bus_start(); bus_stop(); wt(5);
        chk(n_wr == n0, "R9 START discards deferred data", n_wr, n0);
        read_one(8'h04, "R9 address 4 unchanged");

        // Identity with the wrong strap.
        n0 = n_wr;
        bus_start();
        put_byte(ID_BAD, k); chk(!k, "R3 mismatched identity", k, 0);
        put_byte(8'h02, k);  chk(!k, "R3 later byte ignored", k, 0);
        put_byte(8'h11, k);  chk(!k, "R3 data ignored", k, 0);
        bus_stop(); wt(5);
        chk(n_wr == n0, "R3 no strobe", n_wr, n0);

        // Writes refused.
        wr_allow = 1'b0; n0 = n_wr;
        bus_start();
        put_byte(ID_W, k);  chk(k, "R6 identity still acked", k, 1);
        put_byte(8'h03, k); chk(k, "R6 address still acked", k, 1);
        put_byte(8'h5A, k); chk(!k, "R6 data refused", k, 0);
        bus_stop(); wt(5);
        chk(n_wr == n0, "R6 no strobe", n_wr, n0);
        wr_allow = 1'b1;
        read_one(8'h03, "R6 address 3 unchanged");

        // Streaming read across the wrap point.
        set_addr(8'h07); bus_start();
        put_byte(ID_R, k); chk(k, "R1 read identity ack", k, 1);
        get_byte(1'b1, d); chk(d == model[7], "R4 first byte", d, model[7]);
        get_byte(1'b1, d); chk(d == model[8], "R5 byte at wrap address", d, model[8]);
        get_byte(1'b0, d); chk(d == model[0], "R5 wrapped to 0", d, model[0]);
        get_byte(1'b0, d); chk(d == 8'hFF, "R4 released after NACK", d, 8'hFF);
        bus_stop();
        read_one(8'h02, "R8 early data readable");
        read_one(8'h05, "R9 deferred data readable");

        // Busy for a whole write.
        busy = 1'b1; wt(4); n0 = n_wr;
        bus_start();
        put_byte(ID_W, k);  chk(!k, "R7 identity ignored", k, 0);
        put_byte(8'h01, k); put_byte(8'h99, k);
        chk(!k, "R7 data ignored", k, 0);
        bus_stop(); wt(5);
        chk(n_wr == n0, "R7 no strobe", n_wr, n0);
        busy = 1'b0; wt(5);

        // Busy pulse in mid transfer.
        bus_start(); put_byte(ID_W, k);
        busy = 1'b1; wt(4); busy = 1'b0; wt(4);
        put_byte(8'h01, k); chk(!k, "R7 transfer dropped", k, 0);
        bus_stop();
        read_one(8'h01, "R7 address 1 unchanged");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        wt(150000);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule